// File: doc/BRIEF.md
# DSI command packet transmitter

This block sends one display serial interface command-mode packet at a time. Software fills a small register file (a transfer mode bit, a packet header word and up to four 32-bit payload words) and then writes a start request. The engine sends the four header bytes and, for long packets, the payload bytes, least significant byte first. Bytes go out on an 8-bit lane interface with a valid/ready handshake.

There are two start requests. A plain send finishes by setting a sticky completion flag, which software clears by writing one to it. A send-and-turnaround finishes with a one-cycle turnaround request to the lane logic, so that a read response can follow. The completion flag drives an interrupt line, and an enable bit lets software mask it and poll instead. Error-code generation, checksums and the physical layer are outside this block. The fourth header byte is sent as a zero placeholder.

Top module: `dsi_cmd_tx`

## Requirements
- R1: After reset `lane_valid`, `turn_req` and `irq` are low, and every readable register (status, mode, interrupt enable, header, payload) reads as zero.
- R2: The register map is: 0 control, 1 status, 2 mode, 3 interrupt enable, 4 header, 5 to 8 payload words 0 to 3. The header word holds the data type in bits [5:0], the virtual channel in bits [7:6], header byte 1 in bits [15:8], header byte 2 in bits [23:16] and the long-form flag in bit 24. Every packet starts with bytes {vc,dt}, byte 1, byte 2 and then 0x00.
- R3: When the long-form flag is 0, exactly four bytes are sent and the payload registers have no effect on the output.
- R4: When the long-form flag is 1, the header bytes are followed by min(W,16) payload bytes, where W = {byte 2, byte 1}. Payload byte n is taken from payload word n/4, bits [8*(n%4)+7 : 8*(n%4)].
- R5: While `lane_valid` is high and `lane_ready` is low, `lane_data` and `lane_last` hold their values. `lane_last` is high on the final byte of the packet only.
- R6: Mode register bit 0 selects low-power (1) or high-speed (0). The value at the time of the start request is driven on `lane_lp` for the whole transfer.
- R7: Control bit 0 requests a plain send and control bit 1 requests a send with turnaround. If both bits are set, the turnaround form is used. After the last byte of a turnaround send is accepted, `turn_req` is high for exactly one cycle and the completion flag is not set.
- R8: Status bit 0 (completion) rises in the cycle after the last byte of a plain send is accepted. Writing 1 to it clears it and writing 0 has no effect.
- R9: `irq` equals status bit 0 ANDed with interrupt enable register bit 0.
- R10: Status bit 1 reads 1 while a packet is being sent or a turnaround is pending. A start request written while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| lane_data | output | 8 | Packet byte |
| lane_valid | output | 1 | Byte valid |
| lane_ready | input | 1 | Lane accepts the byte |
| lane_last | output | 1 | Final byte of the packet |
| lane_lp | output | 1 | Low-power transfer select |
| turn_req | output | 1 | One-cycle bus turnaround request |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that software leaves the header and payload registers alone while status bit 1 is set. This matters because payload bytes are read from the live registers during the transfer, and a write at that point would legitimately change a stalled byte. The bench writes those registers only while the engine is idle. During transfers it issues only control, status and read accesses, including a start request in the middle of a stalled packet. `lane_ready` is left unconstrained: the bench drives it always high, alternating, and pseudo-randomly.

// File: rtl/dsi_tx_pkg.sv
package dsi_tx_pkg;
    parameter int BYTE_W        = 8;
    parameter int WORD_W        = 32;
    parameter int PAYLOAD_WORDS = 4;
    parameter int HDR_BYTES     = 4;
    parameter int ADDR_W        = 4;

    localparam int PAYLOAD_BYTES = PAYLOAD_WORDS * (WORD_W / BYTE_W);
    localparam int IDX_W         = $clog2(HDR_BYTES + PAYLOAD_BYTES + 1);
    localparam int WSEL_W        = $clog2(PAYLOAD_WORDS);

    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_IRQEN  = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_HDR    = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] A_PL0    = ADDR_W'(5);

    typedef struct packed {
        logic        is_long;
        logic [7:0]  b2;
        logic [7:0]  b1;
        logic [1:0]  vc;
        logic [5:0]  dt;
    } hdr_t;

    localparam int HDR_W = $bits(hdr_t);

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_TURN} tx_state_t;

    typedef logic [PAYLOAD_WORDS-1:0][WORD_W-1:0] payload_t;

    function automatic logic [IDX_W-1:0] payload_len(hdr_t h);
        logic [15:0] wc;
        wc = {h.b2, h.b1};
        if (!h.is_long)
            return '0;
        else if (wc > 16'(PAYLOAD_BYTES))
            return IDX_W'(PAYLOAD_BYTES);
        else
            return wc[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/dsi_tx_regs.sv
module dsi_tx_regs
    import dsi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done_set,
    output logic              start_plain,
    output logic              start_turn,
    output hdr_t              hdr,
    output payload_t          payload,
    output logic              lp_mode,
    output logic              irq
);
    logic done_q, irq_en_q;

    wire ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign start_turn  = ctrl_wr && reg_wdata[1];
    assign start_plain = ctrl_wr && reg_wdata[0] && !reg_wdata[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr      <= '0;
            lp_mode  <= 1'b0;
            irq_en_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_HDR)   hdr      <= hdr_t'(reg_wdata[HDR_W-1:0]);
            if (reg_wr && reg_addr == A_MODE)  lp_mode  <= reg_wdata[0];
            if (reg_wr && reg_addr == A_IRQEN) irq_en_q <= reg_wdata[0];
            if (done_set)
                done_q <= 1'b1;
            else if (reg_wr && reg_addr == A_STATUS && reg_wdata[0])
                done_q <= 1'b0;
        end
    end

    for (genvar g = 0; g < PAYLOAD_WORDS; g++) begin : g_pl
        always_ff @(posedge clk) begin
            if (rst)
                payload[g] <= '0;
            else if (reg_wr && reg_addr == A_PL0 + ADDR_W'(g))
                payload[g] <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_STATUS)     reg_rdata[1:0] = {busy, done_q};
        else if (reg_addr == A_MODE)  reg_rdata[0]   = lp_mode;
        else if (reg_addr == A_IRQEN) reg_rdata[0]   = irq_en_q;
        else if (reg_addr == A_HDR)   reg_rdata[HDR_W-1:0] = hdr;
        else if (reg_addr >= A_PL0 && reg_addr < A_PL0 + ADDR_W'(PAYLOAD_WORDS))
            reg_rdata = payload[WSEL_W'(reg_addr - A_PL0)];
    end

    assign irq = done_q && irq_en_q;

    // R8: completion clears only on a write of one to status bit 0
    a_r8_done_w1c: assert property (@(posedge clk) disable iff (rst)
        $fell(done_q) |-> $past(reg_wr && reg_addr == A_STATUS && reg_wdata[0]));
    // R8: a completion set request always leaves the flag high
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        done_set |=> done_q);
endmodule

// File: rtl/dsi_tx_serializer.sv
module dsi_tx_serializer
    import dsi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_plain,
    input  logic              start_turn,
    input  hdr_t              hdr,
    input  payload_t          payload,
    input  logic              lp_mode,
    output logic [BYTE_W-1:0] lane_data,
    output logic              lane_valid,
    input  logic              lane_ready,
    output logic              lane_last,
    output logic              lane_lp,
    output logic              turn_req,
    output logic              busy,
    output logic              done_set
);
    tx_state_t        state;
    hdr_t             hdr_q;
    logic             turn_q;
    logic [IDX_W-1:0] idx, total_q;
    logic [IDX_W-1:0] pidx;

    wire accept = lane_valid && lane_ready;

    assign lane_valid = (state == ST_SEND);
    assign lane_last  = lane_valid && (idx + IDX_W'(1) == total_q);
    assign turn_req   = (state == ST_TURN);
    assign busy       = (state != ST_IDLE);
    assign done_set   = accept && lane_last && !turn_q;
    assign pidx       = idx - IDX_W'(HDR_BYTES);

    always_comb begin
        if (idx < IDX_W'(HDR_BYTES)) begin
            case (idx[1:0])
                2'd0:    lane_data = {hdr_q.vc, hdr_q.dt};
                2'd1:    lane_data = hdr_q.b1;
                2'd2:    lane_data = hdr_q.b2;
                default: lane_data = '0;
            endcase
        end else begin
            lane_data = payload[pidx[2 +: WSEL_W]][{pidx[1:0], 3'b000} +: BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            hdr_q   <= '0;
            turn_q  <= 1'b0;
            idx     <= '0;
            total_q <= '0;
            lane_lp <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_plain || start_turn) begin
                    state   <= ST_SEND;
                    hdr_q   <= hdr;
                    turn_q  <= start_turn;
                    lane_lp <= lp_mode;
                    idx     <= '0;
                    total_q <= IDX_W'(HDR_BYTES) + payload_len(hdr);
                end
                ST_SEND: if (accept) begin
                    if (lane_last) state <= turn_q ? ST_TURN : ST_IDLE;
                    else           idx   <= idx + IDX_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: a stalled byte keeps its data and last marker
    a_r5_hold_stall: assert property (@(posedge clk) disable iff (rst)
        lane_valid && !lane_ready |=> lane_valid && $stable(lane_data) && $stable(lane_last));
    // R7: turnaround request is a single-cycle pulse
    a_r7_turn_pulse: assert property (@(posedge clk) disable iff (rst)
        turn_req |=> !turn_req);
    // R10: a start request during a stalled transfer does not restart it
    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        lane_valid && !lane_ready && (start_plain || start_turn) |=> $stable(idx) && $stable(total_q));
    // R4: the byte index never passes the longest packet
    a_r4_len_bound: assert property (@(posedge clk) disable iff (rst)
        lane_valid |-> idx < IDX_W'(HDR_BYTES + PAYLOAD_BYTES));
endmodule

// File: rtl/dsi_cmd_tx.sv
module dsi_cmd_tx
    import dsi_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [BYTE_W-1:0] lane_data,
    output logic              lane_valid,
    input  logic              lane_ready,
    output logic              lane_last,
    output logic              lane_lp,
    output logic              turn_req,
    output logic              irq
);
    logic     start_plain, start_turn, busy, done_set, lp_mode;
    hdr_t     hdr;
    payload_t payload;

    dsi_tx_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .done_set(done_set), .start_plain(start_plain), .start_turn(start_turn),
        .hdr(hdr), .payload(payload), .lp_mode(lp_mode), .irq(irq)
    );

    dsi_tx_serializer u_ser (
        .clk(clk), .rst(rst), .start_plain(start_plain), .start_turn(start_turn),
        .hdr(hdr), .payload(payload), .lp_mode(lp_mode), .lane_data(lane_data),
        .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_last(lane_last),
        .lane_lp(lane_lp), .turn_req(turn_req), .busy(busy), .done_set(done_set)
    );

    // R8: interrupt rises only after a final byte was accepted
    a_r8_irq_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(lane_valid && lane_ready && lane_last)
                      || $past(reg_wr && reg_addr == A_IRQEN));
    // R7: the turnaround pulse follows acceptance of a final byte
    a_r7_turn_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(turn_req) |-> $past(lane_valid && lane_ready && lane_last));
endmodule

// File: tb/dsi_cmd_tx_tb.sv
module dsi_cmd_tx_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  lane_data;
    logic        lane_valid, lane_last, lane_lp, turn_req, irq;
    logic        lane_ready = 1'b1;

    int checks = 0, errors = 0, cyc = 0, rmode = 0;
    bit monitor_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsi_cmd_tx u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lane_data(lane_data),
        .lane_valid(lane_valid), .lane_ready(lane_ready), .lane_last(lane_last),
        .lane_lp(lane_lp), .turn_req(turn_req), .irq(irq)
    );

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Reference model state
    logic [7:0]  q[$];
    logic [31:0] m_hdr = '0;
    logic [31:0] m_pl[4] = '{default: '0};
    bit m_lp = 0, m_ie = 0, m_turnflag = 0;
    bit exp_turn = 0, exp_done = 0, exp_lp = 0;

    task automatic load_queue();
        int n;
        q.delete();
        q.push_back(m_hdr[7:0]);
        q.push_back(m_hdr[15:8]);
        q.push_back(m_hdr[23:16]);
        q.push_back(8'h00);
        if (m_hdr[24]) begin
            n = int'(m_hdr[23:8]);
            if (n > 16) n = 16;
            for (int i = 0; i < n; i++) q.push_back(m_pl[i/4][8*(i%4) +: 8]);
        end
    endtask

    always @(posedge clk) begin
        bit busy_before, dset, nturn;
        cyc++;
        if (rst) begin
            q.delete(); m_hdr = '0; m_lp = 0; m_ie = 0; m_turnflag = 0;
            exp_turn = 0; exp_done = 0; exp_lp = 0;
            for (int i = 0; i < 4; i++) m_pl[i] = '0;
        end else begin
            busy_before = (q.size() != 0) || exp_turn;
            dset = 0; nturn = 0;
            if (q.size() != 0 && lane_ready) begin
                void'(q.pop_front());
                if (q.size() == 0) begin
                    if (m_turnflag) nturn = 1; else dset = 1;
                end
            end
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: if (!busy_before && reg_wdata[1:0] != 2'b00) begin
                        load_queue();
                        m_turnflag = reg_wdata[1];
                        exp_lp = m_lp;
                    end
                    4'd1: if (reg_wdata[0]) exp_done = 0;
                    4'd2: m_lp = reg_wdata[0];
                    4'd3: m_ie = reg_wdata[0];
                    4'd4: m_hdr = {7'b0, reg_wdata[24:0]};
                    4'd5, 4'd6, 4'd7, 4'd8: m_pl[reg_addr - 4'd5] = reg_wdata;
                    default: ;
                endcase
            end
            if (dset) exp_done = 1;
            exp_turn = nturn;
        end
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (monitor_on && !rst) begin
            chk(lane_valid == (q.size() != 0), "R5 lane_valid", 32'(lane_valid), 32'(q.size() != 0));
            if (lane_valid && q.size() != 0) begin
                chk(lane_data == q[0], "R2/R3/R4 lane_data", 32'(lane_data), 32'(q[0]));
                chk(lane_last == (q.size() == 1), "R5 lane_last", 32'(lane_last), 32'(q.size() == 1));
                chk(lane_lp == exp_lp, "R6 lane_lp", 32'(lane_lp), 32'(exp_lp));
            end
            chk(turn_req == exp_turn, "R7 turn_req", 32'(turn_req), 32'(exp_turn));
            chk(irq == (exp_done && m_ie), "R9 irq", 32'(irq), 32'(exp_done && m_ie));
        end
    end

    // Ready pattern driver
    always @(negedge clk) begin
        case (rmode)
            0: lane_ready = 1'b1;
            1: lane_ready = cyc[0];
            default: lane_ready = ($urandom % 3) != 0;
        endcase
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((q.size() != 0 || exp_turn) && n < 2000) begin
            @(negedge clk); n++;
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        chk(lane_valid == 0 && turn_req == 0 && irq == 0, "R1 outputs", {lane_valid, turn_req, irq}, 0);
        for (int a = 1; a <= 8; a++) rd_chk(4'(a), 32'h0, "R1 register reset");
        monitor_on = 1;

        // R3: short packet, payload preloaded but ignored, low-power
        for (int i = 0; i < 4; i++) wr(4'(5 + i), 32'hA0B0C0D0 + 32'(i));
        wr(4'd2, 32'h1);
        wr(4'd4, {7'b0, 1'b0, 8'h34, 8'h12, 2'd2, 6'h05});
        wr(4'd0, 32'h1);
        wait_idle();
        rd_chk(4'd1, 32'h1, "R8 done set after plain send");
        wr(4'd1, 32'h0);
        rd_chk(4'd1, 32'h1, "R8 write zero keeps done");
        wr(4'd1, 32'h1);
        rd_chk(4'd1, 32'h0, "R8 write one clears done");

        // R4: long packet, word count 7, high-speed, alternating ready
        rmode = 1;
        wr(4'd2, 32'h0);
        wr(4'd4, {7'b0, 1'b1, 8'h00, 8'd7, 2'd1, 6'h39});
        wr(4'd0, 32'h1);
        wait_idle();

        // R4: word count above 16 is clamped, random ready
        rmode = 2;
        for (int i = 0; i < 4; i++) wr(4'(5 + i), 32'h11223344 * 32'(i + 3));
        wr(4'd4, {7'b0, 1'b1, 8'h01, 8'h2C, 2'd3, 6'h29});
        wr(4'd0, 32'h1);
        wait_idle();

        // R4: long form with zero word count
        wr(4'd4, {7'b0, 1'b1, 8'h00, 8'h00, 2'd0, 6'h39});
        wr(4'd0, 32'h1);
        wait_idle();
        wr(4'd1, 32'h1);

        // R7: both start bits set selects turnaround, done stays clear
        rmode = 0;
        wr(4'd4, {7'b0, 1'b0, 8'h00, 8'h0A, 2'd0, 6'h06});
        wr(4'd0, 32'h3);
        wait_idle();
        rd_chk(4'd1, 32'h0, "R7 no done after turnaround send");

        // R10: start while busy is ignored, busy visible
        rmode = 2;
        wr(4'd4, {7'b0, 1'b1, 8'h00, 8'd16, 2'd2, 6'h39});
        wr(4'd0, 32'h1);
        rd_chk(4'd1, 32'h2, "R10 busy while sending");
        wr(4'd0, 32'h2);
        wr(4'd0, 32'h1);
        wait_idle();
        rd_chk(4'd1, 32'h1, "R10 single completion after ignored starts");

        // R9: interrupt enable
        wr(4'd3, 32'h1);
        repeat (2) @(negedge clk);
        #1;
        chk(irq == 1'b1, "R9 irq enabled with done", 32'(irq), 1);
        wr(4'd1, 32'h1);
        #1;
        chk(irq == 1'b0, "R9 irq after clear", 32'(irq), 0);
        rmode = 0;
        wr(4'd4, {7'b0, 1'b1, 8'h00, 8'd3, 2'd1, 6'h39});
        wr(4'd0, 32'h1);
        wait_idle();
        rd_chk(4'd3, 32'h1, "R2 interrupt enable readback");

        monitor_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule